// File: doc/BRIEF.md
# SPI Serial Clock and Interval Timer

This block paces one SPI frame from the system clock. It does not handle data or decode chip selects. A start pulse captures the timing fields of the attribute word. The block then runs three steps in turn: a setup interval before the first clock edge, a train of serial clock periods, and two closing intervals. The first closing interval runs from the end of the last clock period to chip-select release. The second is the idle gap before the next frame. The shift engine follows the edge strobes. It reports the final bit by raising `frame_done` in the cycle that carries a trailing-edge strobe.

The serial clock period is an odd-or-prime prescaler times a table scaler. Each interval is an odd prescaler times a power of two. The block captures the fields when it accepts a start. It then ignores the attribute input until it returns to idle. The clock idles low. Each period is split into a high half of floor(T/2) cycles and a low half that takes the rest.

Top module: `spi_timing_gen`

## Requirements
- R1: After reset, and whenever the block is idle, `sck`, `lead_stb`, `trail_stb`, `cs_done`, `asc_done`, `dt_done` and `busy` are all low. An asynchronous reset during a frame returns the block to idle at once.
- R2: A start pulse sampled while idle raises `busy` in the next cycle. The setup interval lasts N = P·2^(n+1) cycles, counting the cycle after the start edge as cycle 1. `cs_done` is high only in cycle N. Here P is 1, 3, 5 or 7 for `attr[23:22]` = 0..3, and n is `attr[15:12]`.
- R3: The serial clock period is T = B·S system cycles. B is 2, 3, 5 or 7 for `attr[17:16]` = 0..3. S comes from `attr[3:0]` = c: S = 2·(c+1) for c < 4, and S = 2^c otherwise. `sck` rises in the cycle after `cs_done`, stays high for floor(T/2) cycles, then stays low for T − floor(T/2) cycles.
- R4: `lead_stb` is high only in the first cycle of each high half of `sck`. `trail_stb` is high only in the first cycle of each low half. The two are never high together.
- R5: `frame_done` counts only in a cycle where `trail_stb` is high. The current low half then completes and no further leading edge follows. A `frame_done` raised in any other cycle has no effect.
- R6: The release interval uses `attr[21:20]` as P and `attr[11:8]` as n, with the same odd-times-power-of-two rule as R2. It starts after the final low half. `asc_done` is high only in its last cycle.
- R7: The gap interval uses `attr[19:18]` as P and `attr[7:4]` as n. It follows the release interval, and `dt_done` is high only in its last cycle. `busy` falls in the next cycle.
- R8: Fields are captured at the accepted start. Changing `attr` during the frame changes no timing of that frame.
- R9: A start pulse while `busy` is high has no effect on the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attr | input | 24 | Timing fields of the attribute word (bits 23:0) |
| start | input | 1 | Frame start request, taken only when idle |
| frame_done | input | 1 | Final bit indication from the shift engine |
| sck | output | 1 | Serial clock, idle low |
| lead_stb | output | 1 | First cycle of an `sck` high half |
| trail_stb | output | 1 | First cycle of an `sck` low half |
| cs_done | output | 1 | Last cycle of the setup interval |
| asc_done | output | 1 | Last cycle of the release interval |
| dt_done | output | 1 | Last cycle of the gap interval |
| busy | output | 1 | Frame in progress |

## Verification
A corrupted interval count or a wrong table decode moves a done pulse or an edge strobe by whole cycles. This is visible within a single frame. The bench therefore compares every output against its expected value in every cycle of every frame, not only at the end of the frame. A wrong period state either mistimes the cycle-exact comparison or breaks the strobe-versus-edge relations the checker watches. In both cases it shows up no later than the next serial clock half. A stop flag that is lost or set too early changes the number of leading strobes. That miscount is caught in the cycle where the extra or missing edge would fall.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

  localparam int PRE_W  = 2;
  localparam int SCL_W  = 4;
  localparam int ATTR_W = 24;
  // largest interval 7 * 2^16, largest period 7 * 32768
  localparam int DLY_W  = 19;
  localparam int PER_W  = 18;

  typedef enum logic [2:0] {
    TG_IDLE,
    TG_LEAD,
    TG_CLK,
    TG_TAIL,
    TG_GAP
  } tg_state_e;

  typedef struct packed {
    logic [DLY_W-1:0] lead_dly;
    logic [DLY_W-1:0] tail_dly;
    logic [DLY_W-1:0] gap_dly;
    logic [PER_W-1:0] hi_len;
    logic [PER_W-1:0] lo_len;
  } tg_timing_t;

  // odd prescaler (2p+1) shifted left by (n+1)
  function automatic logic [DLY_W-1:0] delay_len(input logic [PRE_W-1:0] pre,
                                                 input logic [SCL_W-1:0] pw);
    logic [31:0] odd;
    odd = {29'd0, pre, 1'b1};
    return DLY_W'(odd << ({28'd0, pw} + 32'd1));
  endfunction

  function automatic logic [2:0] baud_pre(input logic [PRE_W-1:0] code);
    case (code)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [15:0] baud_scl(input logic [SCL_W-1:0] code);
    if (code < 4'd4) return 16'(({14'd0, code[1:0]} + 16'd1) << 1);
    return 16'd1 << code;
  endfunction

  function automatic logic [PER_W-1:0] sck_period(input logic [PRE_W-1:0] pre,
                                                  input logic [SCL_W-1:0] scl);
    logic [31:0] prod;
    prod = {29'd0, baud_pre(pre)} * {16'd0, baud_scl(scl)};
    return PER_W'(prod);
  endfunction

  function automatic tg_timing_t decode(input logic [ATTR_W-1:0] a);
    tg_timing_t t;
    logic [PER_W-1:0] per;
    per        = sck_period(a[17:16], a[3:0]);
    t.lead_dly = delay_len(a[23:22], a[15:12]);
    t.tail_dly = delay_len(a[21:20], a[11:8]);
    t.gap_dly  = delay_len(a[19:18], a[7:4]);
    t.hi_len   = per >> 1;
    t.lo_len   = per - (per >> 1);
    return t;
  endfunction

endpackage

// File: rtl/spi_tg_cfg.sv
module spi_tg_cfg #(
  parameter int ATTR_W = spi_tg_pkg::ATTR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture,
  input  logic [ATTR_W-1:0]      attr_in,
  output spi_tg_pkg::tg_timing_t timing
);
  logic [ATTR_W-1:0] held;
  logic [ATTR_W-1:0] sel;

  // live fields in the capture cycle so the first interval loads at once
  assign sel    = capture ? attr_in : held;
  assign timing = spi_tg_pkg::decode(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= attr_in;
  end
endmodule

// File: rtl/spi_tg_ivl.sv
module spi_tg_ivl #(
  parameter int W = spi_tg_pkg::DLY_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val - W'(1);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/spi_tg_sck.sv
module spi_tg_sck #(
  parameter int PER_W = spi_tg_pkg::PER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             launch,
  input  logic             stop,
  input  logic [PER_W-1:0] hi_len,
  input  logic [PER_W-1:0] lo_len,
  output logic             sck,
  output logic             lead_stb,
  output logic             trail_stb,
  output logic             period_end
);
  logic [PER_W-1:0] h;

  assign period_end = active && !sck && (h == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck       <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
      h         <= '0;
    end else begin
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
      if (launch) begin
        sck      <= 1'b1;
        lead_stb <= 1'b1;
        h        <= hi_len - PER_W'(1);
      end else if (active) begin
        if (h != '0) begin
          h <= h - PER_W'(1);
        end else if (sck) begin
          sck       <= 1'b0;
          trail_stb <= 1'b1;
          h         <= lo_len - PER_W'(1);
        end else if (!stop) begin
          sck      <= 1'b1;
          lead_stb <= 1'b1;
          h        <= hi_len - PER_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_timing_gen.sv
module spi_timing_gen (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [spi_tg_pkg::ATTR_W-1:0] attr,
  input  logic                          start,
  input  logic                          frame_done,
  output logic                          sck,
  output logic                          lead_stb,
  output logic                          trail_stb,
  output logic                          cs_done,
  output logic                          asc_done,
  output logic                          dt_done,
  output logic                          busy
);
  import spi_tg_pkg::*;

  tg_state_e        st;
  tg_timing_t       tim;
  logic             capture;
  logic             ivl_zero;
  logic             ivl_load;
  logic [DLY_W-1:0] ivl_val;
  logic             period_end;
  logic             stop_req;
  logic             launch;

  assign capture  = start && (st == TG_IDLE);
  assign cs_done  = (st == TG_LEAD) && ivl_zero;
  assign asc_done = (st == TG_TAIL) && ivl_zero;
  assign dt_done  = (st == TG_GAP)  && ivl_zero;
  assign launch   = cs_done;
  assign busy     = (st != TG_IDLE);

  assign ivl_load = capture || (period_end && stop_req) || asc_done;
  assign ivl_val  = capture ? tim.lead_dly :
                    (st == TG_CLK) ? tim.tail_dly : tim.gap_dly;

  spi_tg_cfg #(.ATTR_W(ATTR_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .attr_in (attr),
    .timing  (tim)
  );

  spi_tg_ivl #(.W(DLY_W)) u_ivl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ivl_load),
    .load_val (ivl_val),
    .zero     (ivl_zero)
  );

  spi_tg_sck #(.PER_W(PER_W)) u_sck (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (st == TG_CLK),
    .launch     (launch),
    .stop       (stop_req),
    .hi_len     (tim.hi_len),
    .lo_len     (tim.lo_len),
    .sck        (sck),
    .lead_stb   (lead_stb),
    .trail_stb  (trail_stb),
    .period_end (period_end)
  );

  // last bit reported only alongside a trailing-edge strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stop_req <= 1'b0;
    else if (launch) stop_req <= 1'b0;
    else if (st == TG_CLK && trail_stb && frame_done) stop_req <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TG_IDLE;
    end else begin
      case (st)
        TG_IDLE: if (start)                   st <= TG_LEAD;
        TG_LEAD: if (ivl_zero)                st <= TG_CLK;
        TG_CLK:  if (period_end && stop_req)  st <= TG_TAIL;
        TG_TAIL: if (ivl_zero)                st <= TG_GAP;
        TG_GAP:  if (ivl_zero)                st <= TG_IDLE;
        default:                              st <= TG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_timing_gen_chk.sv
module spi_timing_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic sck,
  input logic lead_stb,
  input logic trail_stb,
  input logic cs_done,
  input logic asc_done,
  input logic dt_done,
  input logic period_end,
  input logic stop_req
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !lead_stb && !trail_stb));

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_done |=> (sck && lead_stb));

  // R4
  lead_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> lead_stb);

  // R4
  trail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> trail_stb);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  // R5
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && stop_req) |=> (busy && !sck && !lead_stb));

  // R6
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_done, asc_done, dt_done}));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dt_done |=> !busy);
endmodule

bind spi_timing_gen spi_timing_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .sck        (sck),
  .lead_stb   (lead_stb),
  .trail_stb  (trail_stb),
  .cs_done    (cs_done),
  .asc_done   (asc_done),
  .dt_done    (dt_done),
  .period_end (period_end),
  .stop_req   (stop_req)
);

// File: tb/spi_timing_gen_bench.sv
module spi_timing_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] attr = '0;
  logic        start = 1'b0;
  logic        frame_done = 1'b0;
  logic        sck, lead_stb, trail_stb, cs_done, asc_done, dt_done, busy;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_timing_gen u_spi_timing_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .attr       (attr),
    .start      (start),
    .frame_done (frame_done),
    .sck        (sck),
    .lead_stb   (lead_stb),
    .trail_stb  (trail_stb),
    .cs_done    (cs_done),
    .asc_done   (asc_done),
    .dt_done    (dt_done),
    .busy       (busy)
  );

  // fields: lead pre, tail pre, gap pre, baud pre, lead n, tail n, gap n,
  // baud code, frames K, then expected N, T, A, D in system cycles
  localparam int NV = 6;
  localparam int VEC [NV][13] = '{
    '{0, 0, 0, 0, 0, 0, 0, 0, 1,  2,   4,  2,  2},
    '{1, 2, 3, 1, 1, 0, 1, 1, 2, 12,  12, 10, 28},
    '{3, 1, 2, 2, 2, 2, 3, 4, 1, 56,  80, 24, 80},
    '{2, 3, 1, 3, 0, 0, 0, 3, 3, 10,  56, 14,  6},
    '{0, 0, 0, 0, 0, 0, 0, 6, 1,  2, 128,  2,  2},
    '{1, 0, 0, 2, 3, 1, 2, 2, 2, 48,  30,  4,  8}
  };

  task automatic chk(input logic act, input logic exp, input string req, input int c);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: got %0b expected %0b", req, c, act, exp);
    end
  endtask

  function automatic logic [23:0] pack_attr(input int v);
    logic [23:0] a;
    a = '0;
    a[23:22] = 2'(VEC[v][0]);
    a[21:20] = 2'(VEC[v][1]);
    a[19:18] = 2'(VEC[v][2]);
    a[17:16] = 2'(VEC[v][3]);
    a[15:12] = 4'(VEC[v][4]);
    a[11:8]  = 4'(VEC[v][5]);
    a[7:4]   = 4'(VEC[v][6]);
    a[3:0]   = 4'(VEC[v][7]);
    return a;
  endfunction

  task automatic run_frame(input int v);
    int k, n, t, a, d, hi, last, ntr;
    logic [23:0] fa;
    k = VEC[v][8]; n = VEC[v][9]; t = VEC[v][10]; a = VEC[v][11]; d = VEC[v][12];
    hi = t / 2;
    last = n + k * t + a + d + 2;
    ntr = 0;
    fa = pack_attr(v);
    @(negedge clk);
    attr = fa;
    start = 1'b1;
    for (int c = 1; c <= last; c++) begin
      logic inrun, e_sck, e_lead, e_trail;
      int ph;
      @(negedge clk);
      if (c == 1) attr = ~fa;         // R8: fields change after capture
      start = (c == 5);               // R9: restart attempt while busy
      inrun = (c >= n + 1) && (c <= n + k * t);
      ph = inrun ? (c - n - 1) % t : 0;
      e_sck   = inrun && (ph < hi);
      e_lead  = inrun && (ph == 0);
      e_trail = inrun && (ph == hi);
      chk(cs_done,   c == n,                     "R2 R9 cs_done", c);
      chk(sck,       e_sck,                      "R3 R8 sck", c);
      chk(lead_stb,  e_lead,                     "R4 R5 lead_stb", c);
      chk(trail_stb, e_trail,                    "R4 trail_stb", c);
      chk(asc_done,  c == n + k * t + a,         "R6 asc_done", c);
      chk(dt_done,   c == n + k * t + a + d,     "R7 dt_done", c);
      chk(busy,      c <= n + k * t + a + d,     "R7 busy", c);
      if (trail_stb) ntr++;
      // R5: frame_done on leading-strobe cycles must be ignored
      frame_done = trail_stb ? (ntr == k) : lead_stb;
    end
    start = 1'b0;
    frame_done = 1'b0;
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sck, 1'b0, "R1 sck", 0);
    chk(busy, 1'b0, "R1 busy", 0);
    chk(cs_done | asc_done | dt_done, 1'b0, "R1 done", 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy, 1'b0, "R1 idle busy", 0);
    chk(lead_stb | trail_stb, 1'b0, "R1 strobes", 0);

    for (int v = 0; v < NV; v++) run_frame(v);

    // R1: reset in the middle of a clocked frame
    attr = pack_attr(4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(sck, 1'b1, "R1 pre-reset sck", 10);
    rst_n = 1'b0;
    #1;
    chk(sck, 1'b0, "R1 reset sck", 10);
    chk(busy, 1'b0, "R1 reset busy", 10);
    chk(lead_stb | trail_stb, 1'b0, "R1 reset strobes", 10);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy, 1'b0, "R1 after reset", 0);
    run_frame(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule